// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that is stepped by a clock-enable stream (`tick_en`) after it passes through a selectable divider. The count runs from zero up to a programmable period value. On the tick where the count equals the period, the count goes back to zero and a one-cycle match pulse is emitted. That pulse can serve as a shift-clock source for a serial unit. A 4-bit postscaler counts match pulses and sets a sticky interrupt flag once a programmed number of matches has been seen.

Software reaches three 8-bit registers through a single write port and a combinational read mux: the count, the period and a control byte. The control byte holds the divider select, the run bit and the postscale ratio. Writing the count or the control byte restarts the hidden divider and postscale counters. A control write does not change the count value.

Top module: `ptmr_top`

## Requirements
- R1: After synchronous reset the count reads 00h, the period reads FFh, the control byte reads 00h, and `irq_flag` and `match_pulse` are 0.
- R2: Registers are selected by `wr_sel`/`rd_sel` as follows: 0 = count, 1 = period, 2 = control, 3 = none (reads 00h, writes ignored). Control bit 7 always reads 0. The other registers read back exactly what was written.
- R3: Control bits [1:0] select the divider. 00 passes every tick, 01 passes every 4th tick, and 10 or 11 pass every 16th tick.
- R4: The count advances only on a divided tick while control bit 2 (run) is 1. When run is 0, or `tick_en` is low, the count holds.
- R5: With period P, the count steps 0,1,…,P. On the divided tick taken at count P, the next cycle shows count 0 and `match_pulse` high for one cycle. With P = 0 the count stays at 0 and every divided tick produces a match.
- R6: Control bits [6:3] hold a value S, and `irq_flag` sets on the (S+1)-th match pulse. It rises in the cycle after that pulse. From a restart the flag therefore rises (P+1)·D·(S+1)+1 cycles later, with D the divide ratio and `tick_en` held high.
- R7: A write to the count or control register clears the divider and postscale counters. No count advance or match happens in the cycle of such a write.
- R8: A control-register write leaves the count value unchanged.
- R9: `irq_flag` is sticky and is cleared by `irq_clr`. If a set and `irq_clr` fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Input clock-enable stream feeding the divider |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 period, 2 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target, same encoding |
| rd_data | output | 8 | Combinational read data |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| match_pulse | output | 1 | One-cycle period-match pulse, usable as a shift clock |

## Verification
The count, `match_pulse` and the divider state all update on the edge that takes a divided tick. The count and the match pulse are therefore visible one cycle after that tick, and `irq_flag` follows one cycle later. The bench drives every input on a falling edge and samples on the next falling edge. Each check is written in terms of the number of rising edges since the write that restarted the timer. The sweeps compare the edge count at which the flag first appears, and the number of match pulses before it, against (P+1)·D·(S+1)+1 and S+1 computed in the bench. Register-effect checks (R7, R8) read the count in the first cycle after the write, and again at the edge where the cleared divider is next due to fire.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int CNT_W  = 8;
    localparam int PS_W   = 4;
    localparam int PRE_W  = 4;
    localparam logic [CNT_W-1:0] PERIOD_RST = '1;

    typedef enum logic [1:0] {
        PRE_DIV1  = 2'b00,
        PRE_DIV4  = 2'b01,
        PRE_DIV16 = 2'b10,
        PRE_DIV16X = 2'b11
    } pre_sel_e;

    typedef struct packed {
        logic            rsvd;
        logic [PS_W-1:0] post;
        logic            run;
        pre_sel_e        pre;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    function automatic logic [PRE_W-1:0] pre_limit(pre_sel_e s);
        case (s)
            PRE_DIV1: return PRE_W'(0);
            PRE_DIV4: return PRE_W'(3);
            default:  return PRE_W'(15);
        endcase
    endfunction
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
    import ptmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     tick,
    input  logic     run,
    input  pre_sel_e sel,
    output logic     adv
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] lim;
    logic             last;

    assign lim  = pre_limit(sel);
    assign last = (pcnt == lim);
    assign adv  = tick & run & last & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (tick && run) begin
            pcnt <= last ? '0 : pcnt + 1'b1;
        end
    end

    // R3
    pcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        pcnt <= lim);

    // R7
    pcnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pcnt == '0));
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
    import ptmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             wr_cnt,
    input  logic             wr_per,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] period,
    output logic             match_q
);
    logic eq;
    assign eq = (count == period);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            period  <= PERIOD_RST;
            match_q <= 1'b0;
        end else begin
            match_q <= adv & eq;
            if (wr_cnt) begin
                count <= wdata;
            end else if (adv) begin
                count <= eq ? '0 : count + 1'b1;
            end
            if (wr_per) begin
                period <= wdata;
            end
        end
    end

    // R5
    match_zero_chk: assert property (@(posedge clk) disable iff (rst)
        match_q |-> (count == '0));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && eq && !wr_cnt) |=> (match_q && count == '0));
endmodule

// File: rtl/ptmr_post.sv
module ptmr_post
    import ptmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            match,
    input  logic [PS_W-1:0] limit,
    input  logic            irq_clr,
    output logic            flag
);
    logic [PS_W-1:0] pscnt;
    logic            set;

    assign set = match & ~clr & (pscnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pscnt <= '0;
        end else if (match) begin
            pscnt <= (pscnt == limit) ? '0 : pscnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= set | (flag & ~irq_clr);
        end
    end

    // R6
    pscnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        pscnt <= limit);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R9
    clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !set) |=> !flag);
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic             match_pulse
);
    ctrl_t            ctrl_q;
    logic             wr_cnt, wr_per, wr_ctl, restart, adv;
    logic [CNT_W-1:0] count, period;

    assign wr_cnt  = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
    assign wr_per  = wr_en && (reg_sel_e'(wr_sel) == SEL_PERIOD);
    assign wr_ctl  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    assign restart = wr_cnt | wr_ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctl) begin
            ctrl_q <= ctrl_t'({1'b0, wr_data[CNT_W-2:0]});
        end
    end

    ptmr_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (restart),
        .tick (tick_en),
        .run  (ctrl_q.run),
        .sel  (ctrl_q.pre),
        .adv  (adv)
    );

    ptmr_count u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .wr_cnt  (wr_cnt),
        .wr_per  (wr_per),
        .wdata   (wr_data),
        .count   (count),
        .period  (period),
        .match_q (match_pulse)
    );

    ptmr_post u_post (
        .clk     (clk),
        .rst     (rst),
        .clr     (restart),
        .match   (match_pulse),
        .limit   (ctrl_q.post),
        .irq_clr (irq_clr),
        .flag    (irq_flag)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_COUNT:  rd_data = count;
            SEL_PERIOD: rd_data = period;
            SEL_CTRL:   rd_data = ctrl_q;
            default:    rd_data = '0;
        endcase
    end

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !wr_cnt) |=> $stable(count));

    // R8
    ctrl_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && !wr_cnt) |=> $stable(count));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rsvd == 1'b0);
endmodule

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;
    logic       clk = 0;
    logic       rst = 1;
    logic       tick_en = 0;
    logic       wr_en = 0;
    logic [1:0] wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic [1:0] rd_sel = 0;
    logic [7:0] rd_data;
    logic       irq_clr = 0;
    logic       irq_flag;
    logic       match_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ptmr_top u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_clr(irq_clr), .irq_flag(irq_flag),
        .match_pulse(match_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        wr_en = 1; wr_sel = sel[1:0]; wr_data = data[7:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int sel, output int val);
        rd_sel = sel[1:0];
        #1 val = rd_data;
    endtask

    function automatic int div_of(input int pre);
        return (pre == 0) ? 1 : (pre == 1) ? 4 : 16;
    endfunction

    task automatic run_cfg(input int pre, input int per, input int ps);
        int n, m, exp_n, v;
        wr(1, per);
        wr(2, 0);
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        wr(0, 0);
        wr(2, (ps << 3) | 4 | pre);
        exp_n = (per + 1) * div_of(pre) * (ps + 1) + 1;
        m = 0;
        for (n = 1; n < 2000; n++) begin
            @(negedge clk);
            if (irq_flag) break;
            if (match_pulse) m++;
        end
        // R6 flag timing; R3 divide; R5 period
        chk("R6 flag edge", n, exp_n);
        chk("R5 matches before flag", m, ps + 1);
        if (per == 0) begin
            rd(0, v);
            // R5 period zero holds count
            chk("R5 count at P=0", v, 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, c;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd(0, v); chk("R1 count", v, 0);
        rd(1, v); chk("R1 period", v, 255);
        rd(2, v); chk("R1 ctrl", v, 0);
        chk("R1 flag", irq_flag, 0);
        chk("R1 match", match_pulse, 0);

        // R2 register access
        wr(1, 8'h5A); rd(1, v); chk("R2 period rw", v, 8'h5A);
        wr(0, 8'h33); rd(0, v); chk("R2 count rw", v, 8'h33);
        wr(2, 8'hFA); rd(2, v); chk("R2 ctrl bit7 zero", v, 8'h7A);
        wr(2, 0);
        wr(3, 8'h77); rd(3, v); chk("R2 sel3 reads zero", v, 0);
        rd(1, v); chk("R2 sel3 write ignored", v, 8'h5A);

        // R4 hold while run off
        tick_en = 1;
        wr(0, 8'h10);
        repeat (10) @(negedge clk);
        rd(0, v); chk("R4 hold run off", v, 8'h10);

        // R4 hold while tick low
        wr(1, 255); wr(0, 0);
        tick_en = 0;
        wr(2, 4);
        repeat (10) @(negedge clk);
        rd(0, v); chk("R4 hold tick low", v, 0);
        tick_en = 1;
        repeat (5) @(negedge clk);
        rd(0, v); chk("R4 counts with tick", v, 5);

        // R8 control write keeps count
        rd(0, c);
        wr(2, 4);
        rd(0, v); chk("R8 count after ctrl write", v, c);
        @(negedge clk);
        rd(0, v); chk("R8 counting resumes", v, c + 1);

        // R7 divider cleared by count write
        wr(2, 0); wr(0, 0);
        wr(2, 5);
        repeat (2) @(negedge clk);
        wr(0, 10);
        rd(0, v); chk("R7 count write value", v, 10);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R7 divider restarted hold", v, 10);
        @(negedge clk);
        rd(0, v); chk("R7 divider restarted step", v, 11);

        // R7 postscaler cleared by count write (P=1, S=3, div1)
        wr(2, 0);
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        wr(1, 1); wr(0, 0);
        wr(2, (3 << 3) | 4);
        repeat (5) @(negedge clk);
        chk("R7 no early flag", irq_flag, 0);
        wr(0, 0);
        for (int n = 1; n < 100; n++) begin
            @(negedge clk);
            if (irq_flag) begin
                chk("R7 postscaler restarted", n, 9);
                break;
            end
        end

        // R3 R5 R6 sweep
        for (int pre = 0; pre < 4; pre++)
            for (int pi = 0; pi < 4; pi++)
                for (int si = 0; si < 3; si++)
                    run_cfg(pre, (pi == 3) ? 5 : pi, (si == 2) ? 3 : si);

        // R9 set wins over clear
        wr(2, 0);
        wr(1, 0); wr(0, 0);
        wr(2, 4);
        repeat (5) @(negedge clk);
        irq_clr = 1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R9 set wins", irq_flag, 1);
        end
        irq_clr = 0;
        wr(2, 0);
        repeat (3) @(negedge clk);
        chk("R9 sticky", irq_flag, 1);
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk("R9 cleared", irq_flag, 0);
        repeat (3) @(negedge clk);
        chk("R9 stays clear", irq_flag, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule